// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the single reservation that backs an atomic read-modify-write built from a linked load and a conditional store. The pipeline sends it one-cycle strobes. A linked load carries its address and opens a reservation on the aligned granule that holds that address. A conditional store carries its address and asks whether the reservation is still intact. Ordinary stores from this core, and stores seen on a snoop port, break the reservation when they hit the reserved granule. An exception-return strobe breaks the reservation no matter what address is held.

For each conditional store the block returns a registered verdict one cycle later. A pass means the store may commit atomically. The current reservation flag is also driven out so the pipeline can observe it. The reservation granule is a power-of-two number of bytes set by a parameter, and it defaults to one 32-bit word. The block does no memory access, no coherence work and no arbitration between cores.

Top module: `rsv_monitor`

## Requirements
- R1: While rst_n is low at a rising edge, rsv_valid, sc_done and sc_pass are all 0 after that edge.
- R2: A linked load (ll_valid=1) sets rsv_valid to 1 after the same edge and records the granule number of ll_addr, which is ll_addr divided by GRAN_BYTES.
- R3: sc_done is 1 in exactly the cycle after a cycle with sc_valid=1. In that cycle sc_pass is 1 only if rsv_valid was 1 in the request cycle and the granule of sc_addr equals the recorded granule. Events arriving in the same cycle as the request do not change its verdict.
- R4: After a conditional store, whether it passes or fails, rsv_valid is 0, unless a linked load arrives in the same cycle.
- R5: A local store (st_valid=1) whose address falls in the recorded granule clears rsv_valid. A local store to any other granule leaves both the flag and the recorded granule unchanged.
- R6: A snoop store (snp_valid=1) follows the same hit-or-ignore rule as R5.
- R7: An exception return (eret_valid=1) clears rsv_valid whatever the address, unless a linked load arrives in the same cycle.
- R8: When a linked load and any clearing event arrive in the same cycle, rsv_valid ends at 1 and the new load's granule is recorded.
- R9: A second linked load replaces the recorded granule. A later conditional store to the first granule then fails, unless the two granules are the same.
- R10: sc_pass is never 1 in a cycle where sc_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ll_valid | input | 1 | Linked-load strobe |
| ll_addr | input | AW | Linked-load byte address |
| sc_valid | input | 1 | Conditional-store strobe |
| sc_addr | input | AW | Conditional-store byte address |
| st_valid | input | 1 | Local ordinary-store strobe |
| st_addr | input | AW | Local store byte address |
| snp_valid | input | 1 | Snooped store strobe |
| snp_addr | input | AW | Snooped store byte address |
| eret_valid | input | 1 | Exception-return strobe |
| sc_done | output | 1 | Verdict valid, one cycle after sc_valid |
| sc_pass | output | 1 | Conditional store may commit |
| rsv_valid | output | 1 | Current reservation flag |

## Verification
A wrong recorded granule stays hidden until a conditional store arrives. It then shows up as a wrong sc_pass exactly one cycle after that store's request. For that reason the bench sweeps every conditional-store address against many linked-load addresses, so that every granule boundary is compared. A flag that is left set, or that is wrongly cleared, shows on rsv_valid one cycle after the event that caused it. The bench therefore samples rsv_valid after every store, snoop, exception return and load/clear collision. Each store case is then followed by a conditional store to the loaded address, which confirms the recorded granule as well.

// File: rtl/rsv_pkg.sv
// Package for the reservation monitor.
// Holds the action code that the arbiter hands to the state register.
// Assumes nothing beyond a standard SystemVerilog compiler.
package rsv_pkg;

    // One update per cycle for the reservation state
    typedef enum logic [1:0] {
        RSV_HOLD  = 2'd0,
        RSV_SET   = 2'd1,
        RSV_CLEAR = 2'd2
    } rsv_act_e;

    // Index of each address probe in the comparator bank
    localparam int PROBE_SC  = 0;
    localparam int PROBE_ST  = 1;
    localparam int PROBE_SNP = 2;
    localparam int NPROBE    = 3;

endpackage

// File: rtl/rsv_granule_cmp.sv
// Granule comparator.
// Reports a hit when a probe strobe is valid, the reservation is live,
// and the probe's granule number matches the recorded one.
// Assumes both granule numbers arrive already shifted, with the
// in-granule offset bits removed.
module rsv_granule_cmp #(
    parameter int TW = 30
) (
    input  logic          probe_valid,
    input  logic [TW-1:0] probe_tag,
    input  logic          rsv_live,
    input  logic [TW-1:0] rsv_tag,
    output logic          hit
);

    // Combinational match of the probe against the live reservation
    always_comb begin
        hit = probe_valid && rsv_live && (probe_tag == rsv_tag);
    end

endmodule

// File: rtl/rsv_arbiter.sv
// Action arbiter.
// Turns the cycle's events into a single state action.
// A linked load always wins. Otherwise a conditional store (any outcome),
// an exception return, or a granule hit from a local or snooped store
// clears the flag.
// Assumes the hit inputs are already qualified by the live flag.
module rsv_arbiter
    import rsv_pkg::*;
(
    input  logic     ll_valid,
    input  logic     sc_valid,
    input  logic     eret_valid,
    input  logic     st_hit,
    input  logic     snp_hit,
    output rsv_act_e act
);

    // Priority choice: set, then clear, then hold
    always_comb begin
        if (ll_valid) begin
            act = RSV_SET;
        end else if (sc_valid || eret_valid || st_hit || snp_hit) begin
            act = RSV_CLEAR;
        end else begin
            act = RSV_HOLD;
        end
    end

endmodule

// File: rtl/rsv_state.sv
// Reservation state register.
// Holds the flag and the recorded granule number. The granule is loaded
// only on a set, so a cleared reservation keeps its old tag. The old tag
// is harmless because every use is gated by the flag.
// Assumes a synchronous, active-low reset.
module rsv_state
    import rsv_pkg::*;
#(
    parameter int TW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rsv_act_e      act,
    input  logic [TW-1:0] ll_tag,
    output logic          live,
    output logic [TW-1:0] tag
);

    // Flag update following the arbiter's action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= 1'b0;
        end else begin
            case (act)
                RSV_SET:   live <= 1'b1;
                RSV_CLEAR: live <= 1'b0;
                default:   live <= live;
            endcase
        end
    end

    // Granule capture on a linked load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag <= '0;
        end else if (act == RSV_SET) begin
            tag <= ll_tag;
        end
    end

    // R2 / R8: a set action leaves the flag live with the loaded granule
    a_r2_set_captures: assert property (@(posedge clk) disable iff (!rst_n)
        (act == RSV_SET) |=> (live && tag == $past(ll_tag)));

    // R5: a hold action changes neither the flag nor the granule
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (act == RSV_HOLD) |=> ($stable(live) && $stable(tag)));

endmodule

// File: rtl/rsv_verdict.sv
// Verdict register.
// Registers the pass/fail result of a conditional store one cycle after
// the request. The result is taken from the state as it stood at the
// start of the request cycle.
// Assumes sc_hit is already qualified by the live flag.
module rsv_verdict (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_valid,
    input  logic sc_hit,
    output logic sc_done,
    output logic sc_pass
);

    // One-cycle registered verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done <= 1'b0;
            sc_pass <= 1'b0;
        end else begin
            sc_done <= sc_valid;
            sc_pass <= sc_valid && sc_hit;
        end
    end

    // R3: a request produces a verdict on the next cycle
    a_r3_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |=> sc_done);

    // R3: no verdict appears without a request
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |=> !sc_done);

    // R10: a pass is always accompanied by a verdict
    a_r10_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> sc_done);

endmodule

// File: rtl/rsv_monitor.sv
// Load-linked reservation monitor, top level.
// Splits each address into its granule number, runs a bank of comparators
// against the recorded granule, arbitrates the cycle's events into one
// state action, and registers the conditional-store verdict.
// Assumes GRAN_BYTES is a power of two smaller than 2**AW, and that every
// strobe lasts one cycle per event.
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int AW         = 32,
    parameter int GRAN_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ll_valid,
    input  logic [AW-1:0] ll_addr,
    input  logic          sc_valid,
    input  logic [AW-1:0] sc_addr,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic          snp_valid,
    input  logic [AW-1:0] snp_addr,
    input  logic          eret_valid,
    output logic          sc_done,
    output logic          sc_pass,
    output logic          rsv_valid
);

    localparam int GSH = $clog2(GRAN_BYTES);
    localparam int TW  = AW - GSH;

    logic [TW-1:0] ll_tag;
    logic [TW-1:0] rsv_tag;
    logic          rsv_live;
    logic [NPROBE-1:0] probe_valid;
    logic [NPROBE-1:0] probe_hit;
    logic [TW-1:0]     probe_tag [NPROBE];
    rsv_act_e      act;

    // Granule numbers of every incoming address
    always_comb begin
        ll_tag                = ll_addr[AW-1:GSH];
        probe_tag[PROBE_SC]   = sc_addr[AW-1:GSH];
        probe_tag[PROBE_ST]   = st_addr[AW-1:GSH];
        probe_tag[PROBE_SNP]  = snp_addr[AW-1:GSH];
        probe_valid[PROBE_SC]  = sc_valid;
        probe_valid[PROBE_ST]  = st_valid;
        probe_valid[PROBE_SNP] = snp_valid;
    end

    // Offset bits inside a granule play no part in any decision
    generate
        if (GSH > 0) begin : g_offset
            logic unused_offset;
            assign unused_offset = ^{ll_addr[GSH-1:0], sc_addr[GSH-1:0],
                                     st_addr[GSH-1:0], snp_addr[GSH-1:0]};
        end
    endgenerate

    // One comparator per address probe
    generate
        for (genvar p = 0; p < NPROBE; p++) begin : g_probe
            rsv_granule_cmp #(.TW(TW)) u_cmp (
                .probe_valid (probe_valid[p]),
                .probe_tag   (probe_tag[p]),
                .rsv_live    (rsv_live),
                .rsv_tag     (rsv_tag),
                .hit         (probe_hit[p])
            );
        end
    endgenerate

    rsv_arbiter u_arb (
        .ll_valid   (ll_valid),
        .sc_valid   (sc_valid),
        .eret_valid (eret_valid),
        .st_hit     (probe_hit[PROBE_ST]),
        .snp_hit    (probe_hit[PROBE_SNP]),
        .act        (act)
    );

    rsv_state #(.TW(TW)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .ll_tag (ll_tag),
        .live   (rsv_live),
        .tag    (rsv_tag)
    );

    rsv_verdict u_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .sc_valid (sc_valid),
        .sc_hit   (probe_hit[PROBE_SC]),
        .sc_done  (sc_done),
        .sc_pass  (sc_pass)
    );

    assign rsv_valid = rsv_live;

    // R1: reset leaves every output low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!rsv_valid && !sc_done && !sc_pass));

    // R2: a linked load raises the flag on the next cycle
    a_r2_ll_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ll_valid |=> rsv_valid);

    // R4: a conditional store without a load drops the flag
    a_r4_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !ll_valid) |=> !rsv_valid);

    // R7: an exception return without a load drops the flag
    a_r7_eret_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_valid && !ll_valid) |=> !rsv_valid);

    // R3: a request against a dead flag never passes
    a_r3_dead_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !rsv_valid) |=> !sc_pass);

    // R5: a local store hitting the granule drops the flag
    a_r5_store_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && rsv_valid && !ll_valid &&
         st_addr[AW-1:GSH] == rsv_tag) |=> !rsv_valid);

    // R6: a snooped store hitting the granule drops the flag
    a_r6_snoop_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && rsv_valid && !ll_valid &&
         snp_addr[AW-1:GSH] == rsv_tag) |=> !rsv_valid);

endmodule

// File: tb/rsv_monitor_tb.sv
`timescale 1ns/1ps
module rsv_monitor_tb;

    localparam int AW = 8;
    localparam int GB = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ll_valid, sc_valid, st_valid, snp_valid, eret_valid;
    logic [AW-1:0] ll_addr, sc_addr, st_addr, snp_addr;
    logic          sc_done, sc_pass, rsv_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rsv_monitor #(.AW(AW), .GRAN_BYTES(GB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .snp_valid(snp_valid), .snp_addr(snp_addr),
        .eret_valid(eret_valid),
        .sc_done(sc_done), .sc_pass(sc_pass), .rsv_valid(rsv_valid)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        ll_valid = 0; sc_valid = 0; st_valid = 0; snp_valid = 0; eret_valid = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_ll(input int a);
        idle(); ll_valid = 1; ll_addr = AW'(a); step(); idle();
    endtask

    task automatic do_sc(input int a);
        idle(); sc_valid = 1; sc_addr = AW'(a); step(); idle();
    endtask

    // Linked load then conditional store; pass iff same granule
    task automatic scen_sc(input int la, input int sa);
        do_ll(la);
        chk(rsv_valid, 1, "R2 flag after load");
        chk(sc_done, 0, "R10 no verdict without request");
        chk(sc_pass, 0, "R10 no pass without verdict");
        do_sc(sa);
        chk(sc_done, 1, "R3 verdict one cycle later");
        chk(sc_pass, int'((la / GB) == (sa / GB)), "R3 granule compare");
        chk(rsv_valid, 0, "R4 flag cleared by conditional store");
    endtask

    // Linked load, store on one port, then probe by flag and verdict
    task automatic scen_st(input int la, input int sa, input bit snoop);
        int alive;
        alive = int'((la / GB) != (sa / GB));
        do_ll(la);
        if (snoop) begin snp_valid = 1; snp_addr = AW'(sa); end
        else       begin st_valid  = 1; st_addr  = AW'(sa); end
        step(); idle();
        chk(rsv_valid, alive, snoop ? "R6 snoop hit/ignore" : "R5 store hit/ignore");
        do_sc(la);
        chk(sc_pass, alive, snoop ? "R6 granule kept" : "R5 granule kept");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        ll_addr = 0; sc_addr = 0; st_addr = 0; snp_addr = 0;
        rst_n = 0;
        sc_valid = 1;
        ll_valid = 1;
        repeat (3) step();
        // R1: outputs held low despite strobes during reset
        chk(rsv_valid, 0, "R1 reset flag");
        chk(sc_done, 0, "R1 reset verdict");
        chk(sc_pass, 0, "R1 reset pass");
        idle();
        rst_n = 1;
        step();

        // R3: request with no reservation fails
        do_sc(8);
        chk(sc_done, 1, "R3 verdict with dead flag");
        chk(sc_pass, 0, "R3 dead flag fails");

        // R3 / R4 sweep: loads across the space against every SC address
        for (int la = 0; la < 256; la += 5)
            for (int sa = 0; sa < 256; sa++)
                scen_sc(la, sa);

        // R5 / R6 sweep: stores and snoops across every address
        for (int la = 1; la < 256; la += 13)
            for (int sa = 0; sa < 256; sa++)
                scen_st(la, sa, sa[0]);

        // R7: exception return clears regardless of address
        for (int la = 0; la < 256; la += 37) begin
            do_ll(la);
            eret_valid = 1; step(); idle();
            chk(rsv_valid, 0, "R7 eret clears");
            do_sc(la);
            chk(sc_pass, 0, "R7 cleared reservation fails");
        end

        // R8: load collides with eret, store hit, snoop hit and SC
        do_ll(40);
        ll_valid = 1; ll_addr = 100; eret_valid = 1;
        st_valid = 1; st_addr = 40; snp_valid = 1; snp_addr = 40;
        step(); idle();
        chk(rsv_valid, 1, "R8 load wins over clears");
        ll_valid = 1; ll_addr = 200; sc_valid = 1; sc_addr = 100;
        step(); idle();
        chk(sc_pass, 1, "R3 verdict uses start-of-cycle state");
        chk(rsv_valid, 1, "R8 load wins over SC");
        do_sc(201);
        chk(sc_pass, 1, "R8 new granule recorded");

        // R9: second load replaces the granule
        do_ll(16);
        do_ll(64);
        do_sc(17);
        chk(sc_pass, 0, "R9 old granule replaced");
        do_ll(16);
        do_ll(19);
        do_sc(16);
        chk(sc_pass, 1, "R9 same granule reload");

        // R4: SC following a failed SC also fails
        do_ll(12);
        do_sc(0);
        do_sc(12);
        chk(sc_pass, 0, "R4 fail also clears flag");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule